// File: doc/BRIEF.md
# TPM register transaction master over SPI with wait-state polling

This block performs one register access to a TPM device across a mode 0 SPI link. A requester pulses a start strobe along with a direction, a 24-bit register address and a byte count (given as count minus one). The block drops chip select and sends a four-byte header. It then looks at the flow-control bit in the byte that comes back during the final header byte. If the device is not ready, the block clocks out single filler bytes and tests the same bit in each reply. When the device reports ready, the payload moves. If the device stays not ready until the retry budget is used up, the transaction is abandoned.

Write payload bytes come in on a valid/ready byte stream. Read payload bytes go out on a valid/ready byte stream. Backpressure on either stream pauses the serial clock between bytes, and chip select stays low during the pause. A single-cycle done pulse carries an ok/timeout status. The serial clock is the system clock divided by an even parameter.

Top module: `tpm_spi_xact`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and busy, done, rd_valid and wr_ready are all 0.
- R2: The serial clock idles low and toggles only while spi_cs_n is 0. spi_mosi is stable around every rising spi_sck edge. Each byte is shifted most significant bit first, and spi_miso is sampled at the rising edge.
- R3: Header byte 0 is {read flag in bit 7 (1 = read, 0 = write), 0 in bit 6, req_cnt_m1 in bits 5:0}.
- R4: Header bytes 1, 2 and 3 are req_addr[23:16], req_addr[15:8] and req_addr[7:0], in that order.
- R5: spi_cs_n falls on the clock after an accepted start and stays 0 through header, wait and payload bytes. It rises in the same cycle that done pulses, and spi_cs_n equals !busy at all times.
- R6: If bit 0 of the byte received during header byte 3 is 1, the first payload byte follows the header directly, with no wait byte.
- R7: If that bit is 0, the block sends 0x00 wait bytes one at a time until a received wait byte has bit 0 set. The payload then follows and the status is ok (stat_ok = 1).
- R8: If RETRIES consecutive wait bytes all return bit 0 clear, done pulses with stat_ok = 0 and chip select is released. No payload byte is clocked, and no write byte is accepted.
- R9: In a read, each payload byte sent is 0x00, and the received bytes appear in order on rd_data/rd_valid. While rd_valid is 1 and rd_ready is 0, rd_data holds, and no further payload byte is clocked.
- R10: In a write, req_cnt_m1+1 bytes are taken through the wr_valid/wr_ready handshake and sent in order. While wr_valid is 0, the link pauses with chip select still low.
- R11: A start pulse while busy is 1 is ignored. The running transaction is unchanged and no extra transaction follows.
- R12: Within a byte, consecutive rising edges of spi_sck are exactly DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start strobe, taken only while idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 24 | Register address |
| req_cnt_m1 | input | LEN_W | Payload byte count minus one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| stat_ok | output | 1 | Status of the last transaction: 1 ok, 0 wait timeout |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle when wr_valid is 1 |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong header index or a wrong payload counter shows up in the byte stream captured by the device model, which differs in length or content once chip select rises. A fault in the wait-state counter moves the point where the payload starts, or flips stat_ok, in the done cycle of the same transaction. A desynchronised chip select, busy flag or serial clock breaks the per-cycle relation between spi_cs_n, busy and spi_sck, and that shows in the very cycle it occurs.

// File: rtl/tpm_spi_pkg.sv
`timescale 1ns/1ps
package tpm_spi_pkg;
  localparam int ADDR_W   = 24;
  localparam int RD_FLAG  = 7;
  localparam int RDY_BIT  = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_WAIT, ST_DATA} xact_st_t;

  // header byte selected by position within the four-byte preamble
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic rd,
                                          input logic [5:0] cm1,
                                          input logic [ADDR_W-1:0] addr);
    case (idx)
      2'd0:    return {rd, 1'b0, cm1};
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction
endpackage

// File: rtl/tpm_spi_tick.sv
`timescale 1ns/1ps
// Half-period strobe for the serial clock; restarts whenever run is low.
module tpm_spi_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tpm_spi_shift.sv
`timescale 1ns/1ps
// One mode-0 byte exchange per go pulse, MSB first.
module tpm_spi_shift #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       fin,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = DIV / 2;

  logic       active;
  logic       tick;
  logic [2:0] bitn;
  logic [7:0] sh;

  tpm_spi_tick #(.HALF(HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sck    <= 1'b0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        sck    <= 1'b0;
      end else if (tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          sh  <= {sh[6:0], 1'b0};
          if (bitn == 3'd7) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tpm_spi_xact.sv
`timescale 1ns/1ps
module tpm_spi_xact
  import tpm_spi_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int RETRIES = 50,
  parameter int LEN_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_cnt_m1,
  output logic              busy,
  output logic              done,
  output logic              stat_ok,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PW = $clog2(RETRIES + 1);

  xact_st_t          st;
  logic              rd_mode;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cm1_q;
  logic [LEN_W-1:0]  didx;
  logic [1:0]        hidx;
  logic [PW-1:0]     polls;
  logic              need;
  logic              sh_go;
  logic [7:0]        sh_tx;
  logic              sh_fin;
  logic [7:0]        sh_rx;

  tpm_spi_shift #(.DIV(DIV)) u_shift (
    .clk (clk),
    .rst (rst),
    .go  (sh_go),
    .tx  (sh_tx),
    .fin (sh_fin),
    .rx  (sh_rx),
    .sck (spi_sck),
    .mosi(spi_mosi),
    .miso(spi_miso)
  );

  assign busy     = (st != ST_IDLE);
  assign wr_ready = (st == ST_DATA) && need && !rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_mode  <= 1'b0;
      addr_q   <= '0;
      cm1_q    <= '0;
      didx     <= '0;
      hidx     <= '0;
      polls    <= '0;
      need     <= 1'b0;
      sh_go    <= 1'b0;
      sh_tx    <= '0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
      stat_ok  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      sh_go <= 1'b0;
      done  <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_start) begin
          st       <= ST_HDR;
          rd_mode  <= req_read;
          addr_q   <= req_addr;
          cm1_q    <= req_cnt_m1;
          hidx     <= '0;
          polls    <= '0;
          didx     <= '0;
          need     <= 1'b0;
          spi_cs_n <= 1'b0;
          sh_go    <= 1'b1;
          sh_tx    <= hdr_byte(2'd0, req_read, 6'(req_cnt_m1), req_addr);
        end
        ST_HDR: if (sh_fin) begin
          if (hidx == 2'd3) begin
            if (sh_rx[RDY_BIT]) begin
              st   <= ST_DATA;
              need <= 1'b1;
            end else begin
              st    <= ST_WAIT;
              sh_go <= 1'b1;
              sh_tx <= '0;
            end
          end else begin
            hidx  <= hidx + 2'd1;
            sh_go <= 1'b1;
            sh_tx <= hdr_byte(hidx + 2'd1, rd_mode, 6'(cm1_q), addr_q);
          end
        end
        ST_WAIT: if (sh_fin) begin
          if (sh_rx[RDY_BIT]) begin
            st   <= ST_DATA;
            need <= 1'b1;
          end else if (polls == PW'(RETRIES - 1)) begin
            st       <= ST_IDLE;
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            stat_ok  <= 1'b0;
          end else begin
            polls <= polls + 1'b1;
            sh_go <= 1'b1;
            sh_tx <= '0;
          end
        end
        ST_DATA: begin
          if (need && rd_mode && !rd_valid) begin
            sh_go <= 1'b1;
            sh_tx <= '0;
            need  <= 1'b0;
          end else if (need && !rd_mode && wr_valid) begin
            sh_go <= 1'b1;
            sh_tx <= wr_data;
            need  <= 1'b0;
          end
          if (sh_fin) begin
            if (rd_mode) begin
              rd_data  <= sh_rx;
              rd_valid <= 1'b1;
            end
            if (didx == cm1_q) begin
              st       <= ST_IDLE;
              spi_cs_n <= 1'b1;
              done     <= 1'b1;
              stat_ok  <= 1'b1;
            end else begin
              didx <= didx + 1'b1;
              need <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpm_spi_xact_chk.sv
`timescale 1ns/1ps
module tpm_spi_xact_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  a_r5_cs_tracks_busy: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n == !busy);

  a_r2_sck_needs_select: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !spi_cs_n);

  a_r5_release_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> done);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind tpm_spi_xact tpm_spi_xact_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .spi_sck (spi_sck),
  .spi_cs_n(spi_cs_n),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_data (rd_data)
);

// File: tb/tpm_spi_xact_bench.sv
`timescale 1ns/1ps
module tpm_spi_xact_bench;
  localparam int DIV = 4;
  localparam int RETRIES = 50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_start, req_read, wr_valid, rd_ready;
  logic [23:0] req_addr;
  logic [5:0] req_cnt_m1;
  logic [7:0] wr_data;
  logic busy, done, stat_ok, wr_ready, rd_valid;
  logic [7:0] rd_data;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  tpm_spi_xact #(.DIV(DIV), .RETRIES(RETRIES), .LEN_W(6)) u_tpm_spi_xact (
    .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
    .req_addr(req_addr), .req_cnt_m1(req_cnt_m1), .busy(busy), .done(done),
    .stat_ok(stat_ok), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0;
  int inv_err = 0, per_err = 0, done_cnt = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int cfg_wait;
  logic [7:0] rd_seed;
  int dv_bit, dv_k, dv_left, dv_didx;
  bit dv_seen;
  logic [7:0] dv_rx, dv_tx;
  logic miso_q = 1'b0;
  time last_rise;
  byte unsigned log_q[$];
  assign spi_miso = miso_q;

  task automatic dv_next();
    if (dv_k < 3) dv_tx = 8'h00;
    else if (!dv_seen) begin
      if (dv_left == 0) begin dv_seen = 1; dv_tx = 8'h03; end
      else begin dv_left--; dv_tx = 8'hFE; end
    end else begin
      dv_tx = rd_seed + 8'(dv_didx * 37);
      dv_didx++;
    end
  endtask

  always @(negedge spi_cs_n) begin
    dv_bit = 0; dv_k = 0; dv_seen = 0; dv_left = cfg_wait; dv_didx = 0;
    log_q.delete();
    dv_next();
    miso_q = dv_tx[7];
  end

  always @(posedge spi_sck) begin
    if (dv_bit > 0 && ($time - last_rise) != DIV * 4) per_err++;
    last_rise = $time;
    dv_rx = {dv_rx[6:0], spi_mosi};
    dv_bit++;
    if (dv_bit == 8) begin
      log_q.push_back(dv_rx);
      dv_bit = 0;
      dv_k++;
      dv_next();
    end
  end

  always @(negedge spi_sck) miso_q = dv_tx[7 - dv_bit];

  // ---------------- stream sources / sinks ----------------
  byte unsigned wr_q[$];
  byte unsigned rd_got[$];
  int wr_idx = 0;
  bit stall_wr = 0, stall_rd = 0;

  always @(posedge clk) begin
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
    if (rd_valid && rd_ready) rd_got.push_back(rd_data);
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) begin
    cyc++;
    wr_valid <= (wr_idx < wr_q.size()) && (!stall_wr || (cyc % 5 < 2));
    wr_data  <= (wr_idx < wr_q.size()) ? wr_q[wr_idx] : 8'h00;
    rd_ready <= !stall_rd || (cyc % 6 == 0);
    if (!rst) begin
      if (spi_cs_n != !busy) inv_err++;
      if (spi_sck && spi_cs_n) inv_err++;
      if (done && busy) inv_err++;
    end
  end

  // ---------------- transaction driver and reference ----------------
  task automatic run(input bit rd, input logic [23:0] a, input int cm1, input int w,
                     input bit swr, input bit srd, input bit poke);
    int n, d0, nw, mis_w, mis_d;
    bit succ, st;
    byte unsigned exp_q[$];
    cfg_wait = w;
    rd_seed = a[7:0] ^ 8'h5A;
    wr_q.delete();
    if (!rd) for (int j = 0; j <= cm1; j++) wr_q.push_back(8'(8'h30 + j * 11));
    wr_idx = 0;
    rd_got.delete();
    stall_wr = swr; stall_rd = srd;
    d0 = done_cnt;
    req_read = rd; req_addr = a; req_cnt_m1 = 6'(cm1); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
      if (poke && n == 30) begin
        req_start = 1'b1; req_read = !rd; req_addr = 24'h123456; req_cnt_m1 = 6'd0;
      end else req_start = 1'b0;
    end
    st = stat_ok;
    stall_rd = 0;
    repeat (4) @(negedge clk);

    succ = (w <= RETRIES);
    nw = succ ? w : RETRIES;
    exp_q.push_back({rd, 1'b0, 6'(cm1)});
    exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
    for (int j = 0; j < nw; j++) exp_q.push_back(8'h00);
    if (succ) for (int j = 0; j <= cm1; j++) exp_q.push_back(rd ? 8'h00 : wr_q[j]);

    chk(st == succ, succ ? "R7" : "R8", "status at done", st, succ);
    chk(log_q.size() == exp_q.size(), succ ? (w == 0 ? "R6" : "R7") : "R8",
        "bytes under chip select", log_q.size(), exp_q.size());
    if (log_q.size() >= 4) begin
      chk(log_q[0] == exp_q[0], "R3", "header byte 0", log_q[0], exp_q[0]);
      chk({log_q[1], log_q[2], log_q[3]} == a, "R4", "address bytes",
          {log_q[1], log_q[2], log_q[3]}, a);
    end
    mis_w = 0; mis_d = 0;
    for (int j = 4; j < exp_q.size() && j < log_q.size(); j++) begin
      if (j < 4 + nw) begin if (log_q[j] != exp_q[j]) mis_w++; end
      else if (log_q[j] != exp_q[j]) mis_d++;
    end
    chk(mis_w == 0, "R7", "wait byte content", mis_w, 0);
    chk(mis_d == 0, rd ? "R9" : "R10", "payload bytes sent", mis_d, 0);
    if (rd && succ) begin
      int bad = 0;
      chk(rd_got.size() == cm1 + 1, "R9", "read bytes returned", rd_got.size(), cm1 + 1);
      for (int j = 0; j < rd_got.size(); j++)
        if (rd_got[j] != 8'(rd_seed + 8'(j * 37))) bad++;
      chk(bad == 0, "R9", "read byte values", bad, 0);
    end
    if (!rd) chk(wr_idx == (succ ? cm1 + 1 : 0), succ ? "R10" : "R8",
                 "write bytes accepted", wr_idx, succ ? cm1 + 1 : 0);
    if (!rd && !succ) chk(wr_idx == 0, "R8", "no write taken on timeout", wr_idx, 0);
    if (poke) chk(done_cnt - d0 == 1 && !busy, "R11", "start while busy",
                  done_cnt - d0, 1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog expired: actual 1 expected 0");
    report();
  end

  initial begin
    rst = 1'b1; req_start = 1'b0; req_read = 1'b0; req_addr = '0; req_cnt_m1 = '0;
    cfg_wait = 0; rd_seed = 8'h00;
    repeat (5) @(negedge clk);
    // R1: state while and just after reset
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "cs_n/sck in reset",
        {spi_cs_n, spi_sck}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rd_valid && !wr_ready, "R1", "busy/done/rd_valid/wr_ready",
        {busy, done, rd_valid, wr_ready}, 0);
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);

    run(1'b1, 24'hA53C0F, 3, 0, 1'b0, 1'b0, 1'b1);   // R6 R3 R4 R9 R11
    run(1'b0, 24'h0F0024, 0, 2, 1'b1, 1'b0, 1'b0);   // R7 R10 single byte
    run(1'b1, 24'hD40018, 63, 1, 1'b0, 1'b1, 1'b0);  // R9 max length, backpressure
    run(1'b0, 24'h7E8001, 5, RETRIES, 1'b1, 1'b0, 1'b0);  // R7 last allowed wait
    run(1'b1, 24'h00FF42, 2, RETRIES + 1, 1'b0, 1'b0, 1'b0); // R8 read timeout
    run(1'b0, 24'h13579B, 4, RETRIES + 9, 1'b0, 1'b0, 1'b0); // R8 write timeout

    chk(per_err == 0, "R12", "sck rise spacing errors", per_err, 0);
    chk(inv_err == 0, "R5", "per-cycle cs/busy/sck errors (R2)", inv_err, 0);
    report();
  end
endmodule